// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM with a 20-bit word address and a 4-bit data path. The host offers one access at a time on a valid/ready handshake, with an address, write data and a write flag. The controller then drives the RAM's active-low select, write strobe and output enable, and turns the data path around. For reads it returns the fetched nibble with a one-cycle response pulse. The pad tristate sits outside the block. The controller supplies the outgoing value, a drive enable and the incoming value as separate signals.

Every minimum interval of the RAM is given as a picosecond parameter. Each one becomes a cycle count, rounded up against the clock period parameter. The read window is the longest of the cycle, address-access and enable-access minimums. A write places chip select one cycle ahead of the write strobe. The strobe stays low long enough for pulse width, cycle time, address-to-end and data setup, and the data path is driven only from the cycle after the strobe falls.

The `hold_oe` input selects a second write style. In that style output enable stays low through the write. The strobe is then stretched so that the RAM's drivers turn off before the controller drives. The bus is released whenever the controller is idle. One extra idle cycle separates a read from an immediately following write.

Top module: `sram_xfer_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, `ram_cs_n`, `ram_we_n` and `ram_oe_n` are 1, `ram_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read (accepted with `req_we`=0) holds `ram_cs_n`=0 and `ram_oe_n`=0 with `ram_we_n`=1 for NRD = ceil(max(tRC,tAA,tOE)/Tclk) cycles. `rsp_valid` is 1 for exactly one cycle, NRD clock edges after the accepting edge (NRD=2 at a 5 ns clock).
- R3: `rsp_rdata` equals the last value written to the same 20-bit address, sampled from `ram_dq_i` on the edge that ends the read window.
- R4: During a write, `ram_cs_n` falls one cycle before `ram_we_n` falls, and `ram_addr` does not change while `ram_cs_n` is 0.
- R5: In the normal write style (`hold_oe`=0 at acceptance), `ram_oe_n` stays 1. `ram_we_n` is 0 for NWP = max(ceil tWP, 1+ceil tDW, ceil tWC-1, ceil tAW-1, ceil tCW-1) cycles. `ram_dq_oe` is 1 in all but the first of those cycles, and `req_ready` returns 1+NWP edges after acceptance (4 at a 5 ns clock).
- R6: In the held-enable write style (`hold_oe`=1 at acceptance), `ram_oe_n` is 0 while `ram_cs_n` is 0. The strobe lasts NWH = max(ceil tWP, ceil tWHZ + ceil tDW, the cycle, address and select limits) cycles, and drive starts after ceil tWHZ cycles of strobe. `req_ready` returns 1+NWH edges after acceptance (5 at 5 ns).
- R7: A write accepted when the previous accepted access was a read waits max(1, ceil tHZ) extra cycles with all strobes high before `ram_cs_n` falls.
- R8: Measured at the RAM pins, write pulse, select-to-end, address-to-end and data-setup minimums are met, and the controller never drives the data path while the RAM may be driving it.
- R9: A write ends with `ram_we_n` and `ram_cs_n` rising on the same edge, and `ram_dq_oe` falls on that edge.
- R10: `req_ready` is 0 from the accepting edge until the access completes. A request held on `req_valid` during that time has no effect on the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Controller idle and able to accept |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write data |
| hold_oe | input | 1 | Write style: 1 keeps output enable low during writes |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Read data |
| ram_addr | output | 20 | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_o | output | 4 | Value to drive on the RAM data path |
| ram_dq_oe | output | 1 | Drive enable for the data path |
| ram_dq_i | input | 4 | Value seen on the RAM data path |

## Verification
Results are due at fixed edges counted from the accepting edge, with a 5 ns clock. The read response appears 2 edges later. Ready returns 4 edges after a normal write, 5 after a held-enable write, and one edge later again when a turnaround cycle is inserted. The bench drives every request at a falling edge and counts rising edges until it sees the result at a following falling edge. It compares that count with values it computes from the nanosecond minimums. During each access it also tallies the cycles that select, strobe, enable and drive are active. A behavioural RAM beside the bench time-stamps pin edges, presents wrong data until access time has elapsed and counts timing and contention breaches. The bench checks those counters after every access.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WADDR,
    ST_WPULSE
  } ctl_state_t;

  // Round a picosecond minimum up to whole clock cycles.
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                            input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned a);
    return (a == 0) ? 1 : a;
  endfunction

  // Strobe length: pulse minimum, drive delay plus data setup, and the
  // cycle/address/select minimums less the one select-lead cycle.
  function automatic int unsigned strobe_len(input int unsigned n_wp,
                                             input int unsigned n_delay,
                                             input int unsigned n_dw,
                                             input int unsigned n_wc,
                                             input int unsigned n_aw,
                                             input int unsigned n_cw);
    int unsigned r;
    r = umax(n_wp, n_delay + n_dw);
    r = umax(r, (n_wc > 0) ? n_wc - 1 : 0);
    r = umax(r, (n_aw > 0) ? n_aw - 1 : 0);
    r = umax(r, (n_cw > 0) ? n_cw - 1 : 0);
    return at_least_one(r);
  endfunction

  // Width of a down counter that must hold values up to n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sram_tcount.sv
`timescale 1ns/1ps
module sram_tcount #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned N_RD   = 1,
  parameter int unsigned N_WPN  = 2,
  parameter int unsigned N_WPH  = 2,
  parameter int unsigned N_WHZ  = 1,
  parameter int unsigned N_TURN = 1,
  parameter int unsigned CW     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic req_we,
  input  logic hold_oe,
  output logic req_ready,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_drive,
  output logic rd_capture
);

  localparam logic [CW-1:0] L_RD    = CW'(N_RD - 1);
  localparam logic [CW-1:0] L_TURN  = CW'(N_TURN - 1);
  localparam logic [CW-1:0] L_WPN   = CW'(N_WPN - 1);
  localparam logic [CW-1:0] L_WPH   = CW'(N_WPH - 1);
  // Drive while the remaining count is at or below these limits.
  localparam logic [CW-1:0] L_DRV_N = CW'(N_WPN - 2);
  localparam logic [CW-1:0] L_DRV_H = CW'(N_WPH - 1 - N_WHZ);

  ctl_state_t    st, st_nx;
  logic          last_rd, hold_q;
  logic          ld;
  logic [CW-1:0] ld_val, cnt;
  logic          cnt_zero;

  // Named internal events.
  logic in_select, in_strobe, write_phase, read_done, drive_lim_hit;

  sram_tcount #(.W(CW)) u_tcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .cnt      (cnt),
    .zero     (cnt_zero)
  );

  always_comb begin
    st_nx  = st;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st)
      ST_IDLE: begin
        if (req_fire) begin
          if (!req_we) begin
            st_nx  = ST_READ;
            ld     = 1'b1;
            ld_val = L_RD;
          end else if (last_rd) begin
            st_nx  = ST_TURN;
            ld     = 1'b1;
            ld_val = L_TURN;
          end else begin
            st_nx  = ST_WADDR;
          end
        end
      end
      ST_TURN:   if (cnt_zero) st_nx = ST_WADDR;
      ST_WADDR: begin
        st_nx  = ST_WPULSE;
        ld     = 1'b1;
        ld_val = hold_q ? L_WPH : L_WPN;
      end
      ST_WPULSE: if (cnt_zero) st_nx = ST_IDLE;
      ST_READ:   if (cnt_zero) st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      last_rd <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      st <= st_nx;
      if (req_fire) begin
        last_rd <= !req_we;
        hold_q  <= hold_oe && req_we;
      end
    end
  end

  assign in_select     = (st == ST_READ) || (st == ST_WADDR) || (st == ST_WPULSE);
  assign in_strobe     = (st == ST_WPULSE);
  assign write_phase   = (st == ST_WADDR) || in_strobe;
  assign read_done     = (st == ST_READ) && cnt_zero;
  assign drive_lim_hit = cnt <= (hold_q ? L_DRV_H : L_DRV_N);

  assign req_ready  = (st == ST_IDLE);
  assign cs_n       = !in_select;
  assign we_n       = !in_strobe;
  assign oe_n       = !((st == ST_READ) || (hold_q && write_phase));
  assign dq_drive   = in_strobe && drive_lim_hit;
  assign rd_capture = read_done;

  // ---------------- assertions ----------------
  int unsigned we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_run <= 0;
    else        we_run <= we_n ? 0 : we_run + 1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && we_n && oe_n && !dq_drive));

  a_r4_cs_leads_we: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> ($past(cs_n) == 1'b0));

  a_r9_end_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($rose(cs_n) && !dq_drive));

  a_r5_drive_inside: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> (!we_n && !cs_n && ($past(we_n) == 1'b0)));

  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_run >= N_WPN));

  a_r6_oe_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !oe_n) |-> ($past(oe_n) == 1'b0));

  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && we_n) |-> !cs_n);

endmodule

// File: rtl/sram_dpath.sv
`timescale 1ns/1ps
module sram_dpath #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_capture,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr  <= '0;
      ram_dq_o  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (req_fire) begin
        ram_addr <= req_addr;
        ram_dq_o <= req_wdata;
      end
      rsp_valid <= rd_capture;
      if (rd_capture) rsp_rdata <= ram_dq_i;
    end
  end

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ($past(cs_n) == 1'b0)) |-> $stable(ram_addr));

  a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_xfer_ctrl.sv
`timescale 1ns/1ps
module sram_xfer_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned T_RC_PS   = 10000,
  parameter int unsigned T_AA_PS   = 10000,
  parameter int unsigned T_OE_PS   = 5000,
  parameter int unsigned T_WC_PS   = 10000,
  parameter int unsigned T_AW_PS   = 8000,
  parameter int unsigned T_CW_PS   = 8000,
  parameter int unsigned T_WP_PS   = 8000,
  parameter int unsigned T_DW_PS   = 6000,
  parameter int unsigned T_WHZ_PS  = 6000,
  parameter int unsigned T_HZ_PS   = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              hold_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_i
);

  localparam int unsigned N_RC  = ps_to_cyc(T_RC_PS, CLK_PS);
  localparam int unsigned N_AA  = ps_to_cyc(T_AA_PS, CLK_PS);
  localparam int unsigned N_OE  = ps_to_cyc(T_OE_PS, CLK_PS);
  localparam int unsigned N_WC  = ps_to_cyc(T_WC_PS, CLK_PS);
  localparam int unsigned N_AW  = ps_to_cyc(T_AW_PS, CLK_PS);
  localparam int unsigned N_CW  = ps_to_cyc(T_CW_PS, CLK_PS);
  localparam int unsigned N_WP  = ps_to_cyc(T_WP_PS, CLK_PS);
  localparam int unsigned N_DW  = at_least_one(ps_to_cyc(T_DW_PS, CLK_PS));
  localparam int unsigned N_WHZ = at_least_one(ps_to_cyc(T_WHZ_PS, CLK_PS));
  localparam int unsigned N_HZ  = ps_to_cyc(T_HZ_PS, CLK_PS);

  localparam int unsigned N_RD   = at_least_one(umax(umax(N_RC, N_AA), N_OE));
  localparam int unsigned N_WPN  = strobe_len(N_WP, 1, N_DW, N_WC, N_AW, N_CW);
  localparam int unsigned N_WPH  = strobe_len(N_WP, N_WHZ, N_DW, N_WC, N_AW, N_CW);
  localparam int unsigned N_TURN = at_least_one(N_HZ);
  localparam int unsigned N_MAX  = umax(umax(N_RD, N_TURN), umax(N_WPN, N_WPH));
  localparam int unsigned CW     = cnt_width(N_MAX);

  logic req_fire;
  logic rd_capture;

  assign req_fire = req_valid && req_ready;

  sram_seq #(
    .N_RD   (N_RD),
    .N_WPN  (N_WPN),
    .N_WPH  (N_WPH),
    .N_WHZ  (N_WHZ),
    .N_TURN (N_TURN),
    .CW     (CW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .req_we     (req_we),
    .hold_oe    (hold_oe),
    .req_ready  (req_ready),
    .cs_n       (ram_cs_n),
    .we_n       (ram_we_n),
    .oe_n       (ram_oe_n),
    .dq_drive   (ram_dq_oe),
    .rd_capture (rd_capture)
  );

  sram_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_capture (rd_capture),
    .cs_n       (ram_cs_n),
    .ram_dq_i   (ram_dq_i),
    .ram_addr   (ram_addr),
    .ram_dq_o   (ram_dq_o),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

endmodule

// File: tb/sram_xfer_ctrl_bench.sv
`timescale 1ns/1ps
// Behavioural asynchronous RAM: time-stamps pin edges, counts breaches.
module sram_model (
  input  logic        armed,
  input  logic        cs_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [19:0] addr,
  input  logic [3:0]  dq_o,
  input  logic        dq_oe,
  output logic [3:0]  dq_i,
  output int          viol,
  output int          clash
);
  logic [3:0] mem [logic [19:0]];
  realtime t_addr, t_cs_fall, t_we_fall, t_oe_fall, t_dstart, t_rel;
  bit wr_on, was_drv;

  initial begin
    viol = 0; clash = 0; dq_i = '0;
    t_addr = 0; t_cs_fall = 0; t_we_fall = 0; t_oe_fall = 0;
    t_dstart = 0; t_rel = -100.0; wr_on = 0; was_drv = 0;
  end

  function automatic logic [3:0] look(input logic [19:0] a);
    return mem.exists(a) ? mem[a] : 4'h0;
  endfunction

  always @(addr)         t_addr    = $realtime;
  always @(negedge cs_n) t_cs_fall = $realtime;
  always @(negedge we_n) t_we_fall = $realtime;
  always @(negedge oe_n) t_oe_fall = $realtime;
  always @(posedge dq_oe) t_dstart = $realtime;

  task automatic breach(input string what, input realtime got, input realtime need);
    viol++;
    $display("timing violation %s: %0.3f ns < %0.3f ns at %0t", what, got, need, $realtime);
  endtask

  task automatic end_write();
    realtime now;
    now = $realtime;
    if (now - t_we_fall < 8.0) breach("write pulse", now - t_we_fall, 8.0);
    if (now - t_cs_fall < 8.0) breach("select to end", now - t_cs_fall, 8.0);
    if (now - t_addr    < 8.0) breach("address to end", now - t_addr, 8.0);
    if (t_dstart < t_we_fall || now - t_dstart < 6.0)
      breach("data setup", now - t_dstart, 6.0);
    if (!oe_n && now - t_we_fall < 12.0)
      breach("held-enable pulse", now - t_we_fall, 12.0);
    mem[addr] = dq_o;
  endtask

  always @(cs_n or we_n) begin
    if (!armed) wr_on = 0;
    else if (!cs_n && !we_n) wr_on = 1;
    else if (wr_on) begin
      wr_on = 0;
      end_write();
    end
  end

  initial begin
    #0.25;
    forever begin
      realtime now;
      bit drv, ram_on, ok;
      now = $realtime;
      drv = armed && !cs_n && !oe_n &&
            (we_n || ((t_cs_fall < t_we_fall) && (now - t_we_fall < 6.0)));
      if (was_drv && !drv && (cs_n || oe_n)) t_rel = now;
      was_drv = drv;
      ram_on = drv || (now - t_rel < 5.0);
      if (armed && ram_on && dq_oe) begin
        clash++;
        $display("bus contention at %0t", $realtime);
      end
      if (drv) begin
        ok = (now - t_addr >= 9.5) && (now - t_cs_fall >= 9.5) && (now - t_oe_fall >= 4.5);
        dq_i = ok ? look(addr) : ~look(addr);
      end else begin
        dq_i = 4'h0;
      end
      #0.5;
    end
  end
endmodule

module sram_xfer_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, hold_oe = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [3:0]  rsp_rdata, ram_dq_o, ram_dq_i;
  logic [19:0] ram_addr;
  logic        armed = 1'b0;
  int          viol, clash;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  // Expected cycle counts from the nanosecond minimums at a 5 ns clock.
  function automatic int cyc(input real ns);
    return int'($ceil(ns / 5.0));
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int E_RD   = 2;  // max(cyc(10), cyc(5))
  int e_rd, e_pn, e_ph, e_whz, e_turn;

  logic [3:0] sb [logic [19:0]];
  function automatic logic [3:0] sb_get(input logic [19:0] a);
    return sb.exists(a) ? sb[a] : 4'h0;
  endfunction

  sram_xfer_ctrl #(.CLK_PS(5000)) u_sram_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .hold_oe(hold_oe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
  );

  sram_model u_ram (
    .armed(armed), .cs_n(ram_cs_n), .we_n(ram_we_n), .oe_n(ram_oe_n),
    .addr(ram_addr), .dq_o(ram_dq_o), .dq_oe(ram_dq_oe), .dq_i(ram_dq_i),
    .viol(viol), .clash(clash)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $realtime);
    end
  endtask

  task automatic idle_pins(input string req);
    check({req, " cs_n idle"}, ram_cs_n, 1);
    check({req, " we_n idle"}, ram_we_n, 1);
    check({req, " oe_n idle"}, ram_oe_n, 1);
    check({req, " dq_oe idle"}, ram_dq_oe, 0);
    check({req, " ready idle"}, req_ready, 1);
  endtask

  task automatic t_reset_state();
    idle_pins("R1 reset");
    check("R1 reset rsp_valid", rsp_valid, 0);
  endtask

  task automatic do_write(input logic [19:0] a, input logic [3:0] d,
                          input bit hold, input bit turn);
    int lat = 0, we_lo = 0, cs_lo = 0, oe_lo = 0, drv = 0, pulse, v0, c0;
    bit in_ok = 1, lead_ok = 1;
    v0 = viol; c0 = clash;
    pulse = hold ? e_ph : e_pn;
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d; hold_oe = hold;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R10 ready low after accept", req_ready, 0);
    while (!req_ready && lat < 50) begin
      if (!ram_we_n) begin
        we_lo++;
        if (ram_cs_n) lead_ok = 0;
      end else if (!ram_cs_n && we_lo > 0) lead_ok = 0;
      if (!ram_cs_n) cs_lo++;
      if (!ram_oe_n) oe_lo++;
      if (ram_dq_oe) begin
        drv++;
        if (ram_we_n || ram_cs_n) in_ok = 0;
      end
      @(posedge clk); lat++; @(negedge clk);
    end
    sb[a] = d;
    if (hold) begin
      check("R6 held write latency", lat, 1 + e_ph + (turn ? e_turn : 0));
      check("R6 enable low with select", oe_lo, 1 + e_ph);
      check("R6 drive cycles", drv, e_ph - e_whz);
    end else begin
      check("R5 write latency", lat, 1 + e_pn + (turn ? e_turn : 0));
      check("R5 enable stays high", oe_lo, 0);
      check("R5 drive cycles", drv, e_pn - 1);
    end
    if (turn) check("R7 turnaround adds idle", lat - 1 - pulse, e_turn);
    check("R5 strobe cycles", we_lo, pulse);
    check("R4 select lead", cs_lo, pulse + 1);
    check("R9 select and strobe end together", lead_ok, 1);
    check("R9 drive only inside strobe", in_ok, 1);
    idle_pins("R9 after write");
    check("R8 timing breaches", viol - v0, 0);
    check("R8 contention", clash - c0, 0);
  endtask

  task automatic do_read(input logic [19:0] a);
    int lat = 0, cs_lo = 0, oe_lo = 0, v0, c0;
    bit addr_ok = 1;
    v0 = viol; c0 = clash;
    @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = a; hold_oe = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && lat < 50) begin
      if (!ram_cs_n) cs_lo++;
      if (!ram_oe_n && ram_we_n) oe_lo++;
      if (ram_addr != a) addr_ok = 0;
      @(posedge clk); lat++; @(negedge clk);
    end
    check("R2 read latency", lat, e_rd);
    check("R2 select cycles", cs_lo, e_rd);
    check("R2 enable cycles", oe_lo, e_rd);
    check("R4 address held", addr_ok, 1);
    check("R3 read data", rsp_rdata, sb_get(a));
    check("R2 pulse high", rsp_valid, 1);
    @(negedge clk);
    check("R2 pulse one cycle", rsp_valid, 0);
    idle_pins("R1 after read");
    check("R8 read breaches", viol - v0, 0);
    check("R8 read contention", clash - c0, 0);
  endtask

  // Request held on the port while busy must not be taken.
  task automatic t_busy_ignore(input logic [19:0] a, input logic [19:0] b);
    int guard = 0;
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = 4'h9; hold_oe = 0;
    @(posedge clk);
    @(negedge clk);
    req_addr = b; req_wdata = 4'h6;
    check("R10 ready low while busy", req_ready, 0);
    while (!req_ready && guard < 50) begin
      @(posedge clk); guard++; @(negedge clk);
    end
    req_valid = 0;
    sb[a] = 4'h9;
    do_read(b);
    do_read(a);
  endtask

  initial begin
    e_rd   = mx(cyc(10.0), mx(cyc(10.0), cyc(5.0)));
    e_pn   = mx(cyc(8.0), 1 + cyc(6.0));
    e_whz  = cyc(6.0);
    e_ph   = mx(cyc(8.0), e_whz + cyc(6.0));
    e_turn = mx(1, cyc(5.0));
    check("R2 bench read count", e_rd, E_RD);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    armed = 1;
    @(negedge clk);
    t_reset_state();
    do_write(20'h00000, 4'h3, 0, 0);
    do_write(20'hFFFFF, 4'hC, 0, 0);
    do_write(20'h12345, 4'hA, 0, 0);
    do_read(20'h00000);
    do_read(20'hFFFFF);
    do_write(20'hA5A5A, 4'h5, 0, 1);   // follows a read
    do_read(20'h12345);
    do_read(20'hA5A5A);
    do_write(20'h0F0F0, 4'hE, 1, 1);   // held enable after a read
    do_write(20'h0F0F1, 4'h7, 1, 0);   // held enable after a write
    do_read(20'h0F0F0);
    do_read(20'h0F0F1);
    do_read(20'h55555);                // never written
    t_busy_ignore(20'h33333, 20'h44444);
    do_write(20'hFFFFF, 4'h1, 0, 1);
    do_read(20'hFFFFF);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100000.0);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule